// File: doc/BRIEF.md
# Dual-Direction Staging Transceiver

This block moves data between two ports, A and B, in both directions at once. Each direction has its own storage stage, which can run in one of three ways. It can pass data straight through while its load enable is high. It can hold its stored word while the load enable is low and its strobe is steady. It can also take a new word on a rising strobe while the load enable is low. Each direction also has a drive enable. The A-to-B enable is active high and the B-to-A enable is active low. Each enable drives a drive-qualifier output beside the data vector, so the tristate pads stay outside the block.

The block runs on one system clock. The strobe of each direction is an ordinary input, and the block samples it on every clock edge. A strobe edge is the strobe sampled low on one clock edge and high on the next. Each direction keeps a four-state machine that records the sampled load enable and strobe level:
- `LS_PASS_LO`: load enable high, strobe low.
- `LS_PASS_HI`: load enable high, strobe high.
- `LS_ARMED`: load enable low, strobe low.
- `LS_SPENT`: load enable low, strobe high.

On every edge the next state follows from the sampled load enable and strobe, so any state can move to any other. The transitions have these names:
- **pass**: into either pass state, because the load enable is high.
- **arm**: into `LS_ARMED`.
- **fire**: from `LS_ARMED` or `LS_PASS_LO` into `LS_SPENT`. This is the only transition that loads the sampled input word.
- **settle**: from `LS_PASS_HI` or `LS_SPENT` into `LS_SPENT`. It loads nothing.

In the pass states the stage also copies the input word on every edge, so the word shown while passing is kept when the load enable falls. Reset forces `LS_SPENT` and clears the stored word.

Top module: `bidir_stage_xcvr`

## Requirements
- R1: While `ab_load_en` is 1, `b_out` equals `a_in` in the same cycle, whatever `ab_strobe` does.
- R2: While `ab_load_en` is 0 and no strobe edge is sampled, `b_out` does not change, even when `a_in` changes.
- R3: A strobe edge sampled while `ab_load_en` is 0 loads the sampled `a_in`. `b_out` shows that word from the clock edge of the capture onward.
- R4: If `ab_load_en` falls while `ab_strobe` is already high, `b_out` keeps the last word it showed. Nothing new is loaded until the strobe is sampled low and then high again.
- R5: `b_drive` equals `ab_drive_en` (active high). Deasserting it leaves the stored word intact, and `b_out` still shows that word.
- R6: `a_drive` is 1 exactly while `ba_drive_n` is 0 (active low).
- R7: The B-to-A direction (`b_in`, `ba_load_en`, `ba_strobe`, `a_out`) behaves as R1 to R4 describe. It is unaffected by the A-to-B controls, and the A-to-B direction is unaffected by the B-to-A controls.
- R8: During and after reset both stored words are 0 and both strobes count as previously high. A strobe already high when reset is released is not an edge.
- R9: The data width is the parameter `W`, 18 by default, and each direction's W bits share one set of controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Word arriving at port A |
| b_in | input | W | Word arriving at port B |
| ab_load_en | input | 1 | A-to-B pass-through enable |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_drive_en | input | 1 | B port drive enable, active high |
| ba_load_en | input | 1 | B-to-A pass-through enable |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_drive_n | input | 1 | A port drive enable, active low |
| b_out | output | W | Word presented at port B |
| b_drive | output | 1 | B port drive qualifier |
| a_out | output | W | Word presented at port A |
| a_drive | output | 1 | A port drive qualifier |

## Verification
Pass-through is tested with changing words while the strobe toggles, which shows that the strobe is ignored in that mode. Hold is tested by changing the input word under a steady strobe, and capture by a low-then-high strobe. Together these separate a missed edge from a spurious one. Dropping the load enable with the strobe high, and releasing reset with the strobe high, both test that a level is not taken for an edge. A long random mix of both directions, with independent controls, is compared against a reference model every cycle; this exposes any cross-coupling between directions and any polarity slip in the drive enables.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        LS_PASS_LO = 2'd0,
        LS_PASS_HI = 2'd1,
        LS_ARMED   = 2'd2,
        LS_SPENT   = 2'd3
    } lane_state_e;

    function automatic lane_state_e lane_next(input logic load_en, input logic strobe);
        if (load_en) begin
            return strobe ? LS_PASS_HI : LS_PASS_LO;
        end
        return strobe ? LS_SPENT : LS_ARMED;
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    input  logic         load_en,
    input  logic         strobe,
    output logic [W-1:0] q_out
);

    lane_state_e  state_q;
    lane_state_e  state_d;
    logic [W-1:0] held_q;
    logic         fire;

    // next state and capture decode
    always_comb begin
        state_d = lane_next(load_en, strobe);
        fire    = 1'b0;
        unique case (state_q)
            LS_PASS_LO: fire = !load_en && strobe;
            LS_ARMED:   fire = !load_en && strobe;
            LS_PASS_HI: fire = 1'b0;
            LS_SPENT:   fire = 1'b0;
        endcase
    end

    // state register and stored word
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_SPENT;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_en || fire) begin
                held_q <= d_in;
            end
        end
    end

    // output: pass-through while enabled, stored word otherwise
    always_comb begin
        q_out = load_en ? d_in : held_q;
    end

endmodule

// File: rtl/xcvr_drive_gate.sv
module xcvr_drive_gate #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic en_pin,
    output logic drive
);

    generate
        if (ACTIVE_LOW) begin : g_low
            assign drive = !en_pin;
        end else begin : g_high
            assign drive = en_pin;
        end
    endgenerate

endmodule

// File: rtl/bidir_stage_xcvr.sv
module bidir_stage_xcvr #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_load_en,
    input  logic         ab_strobe,
    input  logic         ab_drive_en,
    input  logic         ba_load_en,
    input  logic         ba_strobe,
    input  logic         ba_drive_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);

    xcvr_lane #(.W(W)) u_ab (
        .clk     (clk),
        .rst     (rst),
        .d_in    (a_in),
        .load_en (ab_load_en),
        .strobe  (ab_strobe),
        .q_out   (b_out)
    );

    xcvr_lane #(.W(W)) u_ba (
        .clk     (clk),
        .rst     (rst),
        .d_in    (b_in),
        .load_en (ba_load_en),
        .strobe  (ba_strobe),
        .q_out   (a_out)
    );

    xcvr_drive_gate #(.ACTIVE_LOW(1'b0)) u_gate_b (
        .en_pin (ab_drive_en),
        .drive  (b_drive)
    );

    xcvr_drive_gate #(.ACTIVE_LOW(1'b1)) u_gate_a (
        .en_pin (ba_drive_n),
        .drive  (a_drive)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_load_en,
    input logic         ab_strobe,
    input logic         ab_drive_en,
    input logic         ba_load_en,
    input logic         ba_strobe,
    input logic         ba_drive_n,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive
);

    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    p_pass_ab_r1: assert property (@(posedge clk) disable iff (rst)
        ab_load_en |-> b_out == a_in);

    p_hold_ab_r2: assert property (@(posedge clk) disable iff (rst)
        (live && !ab_load_en && !(ab_strobe && !$past(ab_strobe)))
        |=> (ab_load_en || b_out == $past(b_out)));

    p_fire_ab_r3: assert property (@(posedge clk) disable iff (rst)
        (live && !ab_load_en && ab_strobe && !$past(ab_strobe))
        |=> (ab_load_en || b_out == $past(a_in)));

    p_drive_b_r5: assert property (@(posedge clk) disable iff (rst)
        b_drive == ab_drive_en);

    p_drive_a_r6: assert property (@(posedge clk) disable iff (rst)
        a_drive == !ba_drive_n);

    p_pass_ba_r7: assert property (@(posedge clk) disable iff (rst)
        ba_load_en |-> a_out == b_in);

    p_hold_ba_r7: assert property (@(posedge clk) disable iff (rst)
        (live && !ba_load_en && !(ba_strobe && !$past(ba_strobe)))
        |=> (ba_load_en || a_out == $past(a_out)));

    p_fire_ba_r7: assert property (@(posedge clk) disable iff (rst)
        (live && !ba_load_en && ba_strobe && !$past(ba_strobe))
        |=> (ba_load_en || a_out == $past(b_in)));

endmodule

bind bidir_stage_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .b_in        (b_in),
    .ab_load_en  (ab_load_en),
    .ab_strobe   (ab_strobe),
    .ab_drive_en (ab_drive_en),
    .ba_load_en  (ba_load_en),
    .ba_strobe   (ba_strobe),
    .ba_drive_n  (ba_drive_n),
    .b_out       (b_out),
    .b_drive     (b_drive),
    .a_out       (a_out),
    .a_drive     (a_drive)
);

// File: tb/tb_bidir_stage_xcvr.sv
`timescale 1ns/1ps
module tb_bidir_stage_xcvr;
    localparam int W = 18;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_load_en = 0, ab_strobe = 1, ab_drive_en = 0;
    logic         ba_load_en = 0, ba_strobe = 1, ba_drive_n = 1;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    bidir_stage_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_load_en(ab_load_en), .ab_strobe(ab_strobe), .ab_drive_en(ab_drive_en),
        .ba_load_en(ba_load_en), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    // next-cycle stimulus, copied to the inputs by step()
    logic         n_rst = 1;
    logic [W-1:0] n_a = '0, n_b = '0;
    logic         n_leab = 0, n_ckab = 1, n_oeab = 0;
    logic         n_leba = 0, n_ckba = 1, n_oeban = 1;

    // reference model
    logic [W-1:0] m_hab = '0, m_hba = '0;
    logic         m_pab = 1, m_pba = 1;

    typedef struct {
        logic [W-1:0] b;
        logic [W-1:0] a;
        logic         bd;
        logic         ad;
        string        tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic m_edge();
        if (rst) begin
            m_hab = '0; m_pab = 1'b1;
            m_hba = '0; m_pba = 1'b1;
        end else begin
            if (ab_load_en || (ab_strobe && !m_pab)) m_hab = a_in;
            m_pab = ab_strobe;
            if (ba_load_en || (ba_strobe && !m_pba)) m_hba = b_in;
            m_pba = ba_strobe;
        end
    endtask

    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        m_edge();
        rst = n_rst; a_in = n_a; b_in = n_b;
        ab_load_en = n_leab; ab_strobe = n_ckab; ab_drive_en = n_oeab;
        ba_load_en = n_leba; ba_strobe = n_ckba; ba_drive_n = n_oeban;
        e.b   = ab_load_en ? a_in : m_hab;
        e.a   = ba_load_en ? b_in : m_hba;
        e.bd  = ab_drive_en;
        e.ad  = !ba_drive_n;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares every queued expectation after the drive settles
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (b_out !== e.b || a_out !== e.a || b_drive !== e.bd || a_drive !== e.ad) begin
                    errors++;
                    $display("FAIL %s: b_out=%h a_out=%h b_drive=%b a_drive=%b expected b_out=%h a_out=%h b_drive=%b a_drive=%b",
                             e.tag, b_out, a_out, b_drive, a_drive, e.b, e.a, e.bd, e.ad);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset with both strobes high
        repeat (3) step("R8 in reset");
        n_rst = 0; n_a = 18'h1F0F0; n_b = 18'h0ABCD;
        step("R8 release, strobe high is no edge");
        step("R8 still cleared");

        // R9: width
        checks++;
        if ($bits(dut.b_out) != 18) begin
            errors++;
            $display("FAIL R9: width=%0d expected 18", $bits(dut.b_out));
        end

        // R2 / R3: A to B capture and hold
        n_ckab = 0; step("R2 hold strobe low");
        n_a = 18'h2A5A5; n_ckab = 1; step("R3 edge sampled");
        n_a = 18'h01234; step("R3 captured word shown");
        n_a = 18'h3FFFF; step("R2 hold with strobe high");
        n_ckab = 0; step("R2 hold after strobe fall");
        n_a = 18'h00001; step("R2 hold input change");

        // R1: pass-through with strobe toggling
        n_leab = 1;
        for (int i = 0; i < 6; i++) begin
            n_a = 18'h11111 * (i + 1);
            n_ckab = i[0];
            step("R1 pass-through");
        end

        // R4: load enable falls while strobe high
        n_ckab = 1; n_a = 18'h2BEEF; step("R1 pass strobe high");
        n_leab = 0; n_a = 18'h05555; step("R4 fall with strobe high");
        n_a = 18'h0AAAA; step("R4 no capture");
        n_ckab = 0; step("R4 strobe low");
        n_ckab = 1; n_a = 18'h1CAFE; step("R4 new edge");
        n_a = 18'h00F00; step("R4 capture after new edge");

        // R5: drive enable gates only the qualifier
        n_oeab = 1; step("R5 drive on");
        n_oeab = 0; n_a = 18'h3ABCD; step("R5 drive off word kept");
        n_oeab = 1; step("R5 drive back on word kept");

        // R6: active-low enable on A
        n_oeban = 0; step("R6 drive on");
        n_oeban = 1; step("R6 drive off");

        // R7: B to A, with A to B controls churning
        n_ckba = 0; step("R7 arm");
        n_b = 18'h13579; n_ckba = 1; n_leab = 1; step("R7 edge");
        n_b = 18'h2468A; n_ckab = 0; step("R7 captured");
        n_leba = 1; n_b = 18'h0F0F0; step("R7 pass");
        n_ckba = 1; n_leba = 0; n_b = 18'h00777; step("R7 fall strobe high");
        n_b = 18'h3C3C3; n_ckab = 1; step("R7 hold");

        // random mix of both directions
        for (int i = 0; i < 800; i++) begin
            n_a = W'($urandom); n_b = W'($urandom);
            n_leab = ($urandom_range(0, 3) == 0);
            n_leba = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 0) n_ckab = !n_ckab;
            if ($urandom_range(0, 1) == 0) n_ckba = !n_ckba;
            n_oeab = $urandom_range(0, 1) == 1;
            n_oeban = $urandom_range(0, 1) == 1;
            step("random R1 R2 R3 R4 R5 R6 R7");
        end

        repeat (3) @(negedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule